// File: doc/BRIEF.md
# Redirect-Cache Invalidation Queue Consumer

This block drains a circular ring of invalidation commands that software keeps in memory. Software writes 16-byte commands into ring slots and then moves a tail pointer forward. The block owns the head pointer. It fetches the command in the head slot over a simple memory port and asks the redirect-entry cache to drop one entry by index. When the command requests it, the block also stores a completion word to a memory address that software polls. Only after all of that does the block move the head forward by one slot.

The ring holds 4096 slots and the slot index wraps modulo 4096. Software treats the ring as full when the slot after the tail is the head, so one slot always stays unused. The block handles exactly one command at a time, strictly in slot order. Software controls it through four configuration selects: ring base, head, tail and run enable. The current head, the current tail and a sticky error flag are readable at the ports.

Top module: `inv_cmdq_engine`

## Requirements
- R1: After reset, head and tail read 0, the error flag reads 0, and neither `mem_req` nor `inv_valid` is asserted.
- R2: No memory request and no invalidate starts while the enable bit is 0 or while head equals tail.
- R3: The first command word is read from `base + head*16` and the second from `base + head*16 + 8`. The base is taken from write-data bits 63:12 of a base write, and bits 11:0 are ignored. Address and direction stay stable while a request waits for `mem_ack`.
- R4: A command whose first word has bit 4 = 0 raises `inv_valid` with `inv_index` equal to that word's bits 23:8. The index holds steady until `inv_done`. Bits 3:0, 7:6 and 63:24 of that word have no effect.
- R5: When bit 5 of the first word is 1, the second word is fetched as a notify address. After `inv_done`, the value 64'h1 is written there. When bit 5 is 0, neither the second-word read nor the write takes place.
- R6: Head advances by exactly one slot per command, and only after the invalidate is acknowledged and any notify write is acknowledged. A memory request and an invalidate are never outstanding together.
- R7: A command with bit 4 = 1 produces no invalidate and no notify write. It still advances head, and it sets the error flag. The error flag stays set until reset.
- R8: Invalidates are issued in the order of the ring slots.
- R9: The slot after 4095 is slot 0, and addressing follows the wrapped index.
- R10: A configuration write with `cfg_sel` 0 sets the base, 1 sets the head, 2 sets the tail from bits 11:0, and 3 sets the enable from bit 0. A head write takes effect only while the enable is 0 and no command is in progress; otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 head, 2 tail, 3 enable |
| cfg_wdata | input | 64 | Configuration write data |
| q_head | output | 32 | Current head slot (zero-extended) |
| q_tail | output | 32 | Current tail slot (zero-extended) |
| q_err | output | 1 | Sticky unsupported-command flag |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Byte address of the 64-bit word |
| mem_wdata | output | 64 | Write data (completion word) |
| mem_ack | input | 1 | Request accepted; read data valid in the same cycle |
| mem_rdata | input | 64 | Read data |
| inv_valid | output | 1 | Invalidate request to the entry cache |
| inv_index | output | 16 | Entry index to invalidate |
| inv_done | input | 1 | Cache has completed the invalidate |

## Verification
A corrupted head pointer shows up on the very next fetch as a read address that differs from the expected slot. It also shows at `q_head` as soon as the ring drains. A wrong latched command field shows on the next `inv_index`, or as a notify write to an unexpected address or with an unexpected count, within a few cycles of the fetch acknowledge. A skipped or duplicated state shows as an out-of-order or missing entry in the invalidate log, or as a completion word that stays zero when software would be polling it.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  localparam int ENT_W      = 16;
  localparam int KIND_BIT   = 4;
  localparam int NOTE_BIT   = 5;
  localparam int IDX_LSB    = 8;
  localparam int SLOT_SHIFT = 4;
  localparam int BASE_LSB   = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH0,
    ST_FETCH1,
    ST_INVAL,
    ST_NOTIFY,
    ST_RETIRE
  } cmdq_state_e;

  typedef enum logic [1:0] {
    CSEL_BASE = 2'd0,
    CSEL_HEAD = 2'd1,
    CSEL_TAIL = 2'd2,
    CSEL_CTRL = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic             bad_kind;
    logic             want_note;
    logic [ENT_W-1:0] index;
  } cmd_info_t;

  function automatic cmd_info_t decode_word0(input logic [63:0] w);
    cmd_info_t c;
    c.bad_kind  = w[KIND_BIT];
    c.want_note = w[NOTE_BIT];
    c.index     = w[IDX_LSB +: ENT_W];
    return c;
  endfunction

endpackage

// File: rtl/cmdq_cfg.sv
module cmdq_cfg
  import cmdq_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] base_q,
  output logic [IDX_W-1:0]  tail_q,
  output logic              en_q,
  output logic              head_wr,
  output logic [IDX_W-1:0]  head_wval
);

  cfg_sel_e sel;
  assign sel = cfg_sel_e'(cfg_sel);

  assign head_wr   = cfg_we && (sel == CSEL_HEAD);
  assign head_wval = cfg_wdata[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      tail_q <= '0;
      en_q   <= 1'b0;
    end else if (cfg_we) begin
      case (sel)
        CSEL_BASE: base_q <= {cfg_wdata[ADDR_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
        CSEL_TAIL: tail_q <= cfg_wdata[IDX_W-1:0];
        CSEL_CTRL: en_q   <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  // R10
  base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_q[BASE_LSB-1:0] == '0);

endmodule

// File: rtl/cmdq_head.sv
module cmdq_head #(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr,
  input  logic             sw_ok,
  input  logic [IDX_W-1:0] sw_val,
  input  logic             retire,
  input  logic             bad_cmd,
  output logic [IDX_W-1:0] head_q,
  output logic             err_q
);

  function automatic logic [IDX_W-1:0] next_slot(input logic [IDX_W-1:0] s);
    return s + IDX_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (retire)
        head_q <= next_slot(head_q);
      else if (sw_wr && sw_ok)
        head_q <= sw_val;
      if (retire && bad_cmd)
        err_q <= 1'b1;
    end
  end

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

endmodule

// File: rtl/cmdq_fsm.sv
module cmdq_fsm
  import cmdq_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int IDX_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  head,
  input  logic [IDX_W-1:0]  tail,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              inv_valid,
  output logic [ENT_W-1:0]  inv_index,
  input  logic              inv_done,
  output logic              retire,
  output logic              bad_cmd,
  output logic              idle
);

  localparam logic [DATA_W-1:0] NOTE_VAL = DATA_W'(1);

  cmdq_state_e st, st_nx;
  cmd_info_t   cmd_q, word0_dec;
  logic [ADDR_W-1:0] note_q;
  logic pending;

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] b,
                                                  input logic [IDX_W-1:0]  h,
                                                  input logic              second);
    return b + (ADDR_W'(h) << SLOT_SHIFT) + (second ? ADDR_W'(8) : ADDR_W'(0));
  endfunction

  assign pending   = en && (head != tail);
  assign word0_dec = decode_word0(mem_rdata);

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:   if (pending) st_nx = ST_FETCH0;
      ST_FETCH0: if (mem_ack) begin
                   if (word0_dec.bad_kind)       st_nx = ST_RETIRE;
                   else if (word0_dec.want_note) st_nx = ST_FETCH1;
                   else                          st_nx = ST_INVAL;
                 end
      ST_FETCH1: if (mem_ack)  st_nx = ST_INVAL;
      ST_INVAL:  if (inv_done) st_nx = cmd_q.want_note ? ST_NOTIFY : ST_RETIRE;
      ST_NOTIFY: if (mem_ack)  st_nx = ST_RETIRE;
      ST_RETIRE: st_nx = ST_IDLE;
      default:   st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cmd_q  <= '0;
      note_q <= '0;
    end else begin
      st <= st_nx;
      if (st == ST_FETCH0 && mem_ack) cmd_q  <= word0_dec;
      if (st == ST_FETCH1 && mem_ack) note_q <= mem_rdata[ADDR_W-1:0];
    end
  end

  assign mem_req   = (st == ST_FETCH0) || (st == ST_FETCH1) || (st == ST_NOTIFY);
  assign mem_we    = (st == ST_NOTIFY);
  assign mem_addr  = (st == ST_NOTIFY) ? note_q : slot_addr(base, head, st == ST_FETCH1);
  assign mem_wdata = NOTE_VAL;
  assign inv_valid = (st == ST_INVAL);
  assign inv_index = cmd_q.index;
  assign retire    = (st == ST_RETIRE);
  assign bad_cmd   = retire && cmd_q.bad_kind;
  assign idle      = (st == ST_IDLE);

  // R2
  quiet_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !pending) |=> (!mem_req && !inv_valid));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R4
  inv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !inv_done) |=> (inv_valid && $stable(inv_index)));

  // R5
  note_after_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(inv_done));

  // R6
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && inv_valid));

endmodule

// File: rtl/inv_cmdq_engine.sv
module inv_cmdq_engine
  import cmdq_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int IDX_W  = 12,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [REG_W-1:0]  q_head,
  output logic [REG_W-1:0]  q_tail,
  output logic              q_err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              inv_valid,
  output logic [ENT_W-1:0]  inv_index,
  input  logic              inv_done
);

  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  tail_q, head_q, head_wval;
  logic en_q, head_wr, retire, bad_cmd, idle, head_sw_ok;

  cmdq_cfg #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .base_q(base_q), .tail_q(tail_q), .en_q(en_q),
    .head_wr(head_wr), .head_wval(head_wval)
  );

  assign head_sw_ok = !en_q && idle;

  cmdq_head #(.IDX_W(IDX_W)) u_head (
    .clk(clk), .rst_n(rst_n), .sw_wr(head_wr), .sw_ok(head_sw_ok),
    .sw_val(head_wval), .retire(retire), .bad_cmd(bad_cmd),
    .head_q(head_q), .err_q(q_err)
  );

  cmdq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en_q), .base(base_q), .head(head_q),
    .tail(tail_q), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .inv_valid(inv_valid), .inv_index(inv_index), .inv_done(inv_done),
    .retire(retire), .bad_cmd(bad_cmd), .idle(idle)
  );

  assign q_head = REG_W'(head_q);
  assign q_tail = REG_W'(tail_q);

  // R6
  head_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (head_q != $past(head_q)) |-> ($past(retire) || ($past(head_wr) && $past(head_sw_ok))));

  // R10
  head_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (head_wr && en_q && !retire) |=> $stable(head_q));

endmodule

// File: tb/sim_inv_cmdq_engine.sv
module sim_inv_cmdq_engine;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] QB = 64'h0000_0000_4000_3000;
  localparam logic [63:0] NB = 64'h0000_0000_9000_0000;
  localparam int SLOTS = 4096;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [63:0] cfg_wdata = 0;
  logic [31:0] q_head, q_tail;
  logic q_err, mem_req, mem_we, mem_ack, inv_valid, inv_done;
  logic [63:0] mem_addr, mem_wdata, mem_rdata;
  logic [15:0] inv_index;

  always #(CLK_PERIOD/2) clk = ~clk;

  inv_cmdq_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .q_head(q_head), .q_tail(q_tail), .q_err(q_err), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .inv_valid(inv_valid), .inv_index(inv_index), .inv_done(inv_done)
  );

  int checks = 0, errors = 0;
  logic [63:0] qmem [0:2*SLOTS-1];
  logic [63:0] notif_mem [0:511];
  logic note_exp [0:511];
  int   note_pos [0:511];
  logic [15:0] exp_inv [0:1023];
  logic [15:0] inv_log [0:1023];
  int exp_inv_n = 0, inv_n = 0, nk = 0;
  int exp_rd1 = 0, rd1_n = 0, exp_wr = 0, wr_n = 0;
  int exp_slot = 0, sw_tail = 0;
  logic [63:0] last0 = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wrap_slot(input int s);
    return s % SLOTS;
  endfunction

  function automatic logic [63:0] slot_byte(input int s);
    return QB + 64'(s) * 64'd16;
  endfunction

  // memory responder
  initial begin
    mem_ack = 0; mem_rdata = 0;
    forever begin
      @(negedge clk);
      mem_ack = 0;
      if (rst_n && mem_req) begin
        repeat ($urandom % 3) @(negedge clk);
        if (mem_we) begin
          int k;
          k = int'((mem_addr - NB) >> 3);
          wr_n++;
          chk(mem_wdata == 64'h1, "R5 notify value", mem_wdata, 64'h1);
          if (k >= 0 && k < 512) begin
            chk(note_exp[k] == 1'b1, "R5/R7 notify target", 64'(k), 64'(k));
            chk(inv_n >= note_pos[k], "R5 notify after invalidate", 64'(inv_n), 64'(note_pos[k]));
            notif_mem[k] = mem_wdata;
          end else chk(0, "R5 notify address", mem_addr, NB);
        end else begin
          if (mem_addr[3] == 1'b0) begin
            chk(mem_addr == slot_byte(exp_slot), "R3/R9 word0 address", mem_addr, slot_byte(exp_slot));
            exp_slot = wrap_slot(exp_slot + 1);
            last0 = mem_addr;
          end else begin
            rd1_n++;
            chk(mem_addr == last0 + 64'd8, "R3 word1 address", mem_addr, last0 + 64'd8);
          end
          mem_rdata = qmem[int'((mem_addr - QB) >> 3) % (2*SLOTS)];
        end
        mem_ack = 1;
      end
    end
  end

  // cache responder
  initial begin
    inv_done = 0;
    forever begin
      @(negedge clk);
      inv_done = 0;
      if (rst_n && inv_valid) begin
        repeat ($urandom % 4) @(negedge clk);
        inv_log[inv_n] = inv_index;
        inv_n++;
        inv_done = 1;
      end
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic put_cmd(input bit bad, input bit note, input logic [15:0] idx);
    logic [63:0] w0;
    w0 = {$urandom, $urandom};
    w0[4] = bad; w0[5] = note; w0[23:8] = idx;
    qmem[2*sw_tail] = w0;
    qmem[2*sw_tail+1] = note ? (NB + 64'(nk) * 64'd8) : {$urandom, $urandom};
    if (!bad) begin
      exp_inv[exp_inv_n] = idx;
      exp_inv_n++;
    end
    if (note) begin
      note_exp[nk] = !bad;
      note_pos[nk] = exp_inv_n;
      if (!bad) begin exp_rd1++; exp_wr++; end
      nk++;
    end
    sw_tail = wrap_slot(sw_tail + 1);
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (q_head != 32'(sw_tail) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(q_head == 32'(sw_tail), req, 64'(q_head), 64'(sw_tail));
  endtask

  task automatic compare_all();
    chk(inv_n == exp_inv_n, "R4/R7 invalidate count", 64'(inv_n), 64'(exp_inv_n));
    for (int i = 0; i < exp_inv_n && i < inv_n; i++)
      chk(inv_log[i] == exp_inv[i], "R8/R4 invalidate order", 64'(inv_log[i]), 64'(exp_inv[i]));
    chk(rd1_n == exp_rd1, "R5 word1 reads", 64'(rd1_n), 64'(exp_rd1));
    chk(wr_n == exp_wr, "R5 notify writes", 64'(wr_n), 64'(exp_wr));
    for (int k = 0; k < nk; k++)
      chk(notif_mem[k] == (note_exp[k] ? 64'h1 : 64'h0), "R5/R7 completion word",
          notif_mem[k], note_exp[k] ? 64'h1 : 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1207));
    for (int i = 0; i < 512; i++) begin notif_mem[i] = 0; note_exp[i] = 0; note_pos[i] = 0; end
    for (int i = 0; i < 2*SLOTS; i++) qmem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(q_head == 0, "R1 head reset", 64'(q_head), 0);
    chk(q_tail == 0, "R1 tail reset", 64'(q_tail), 0);
    chk(q_err == 0, "R1 err reset", 64'(q_err), 0);
    chk(!mem_req && !inv_valid, "R1 quiet", 64'({mem_req, inv_valid}), 0);

    cfg_write(2'd0, QB | 64'hF);
    put_cmd(0, 1, 16'h1234);
    put_cmd(0, 0, 16'hABCD);
    put_cmd(0, 1, 16'hFFFF);
    cfg_write(2'd2, 64'(sw_tail));
    // R2: disabled, nothing may start
    begin
      bit busy = 0;
      for (int i = 0; i < 30; i++) begin @(negedge clk); busy |= mem_req | inv_valid; end
      chk(!busy, "R2 idle while disabled", 64'(busy), 0);
    end
    chk(q_head == 0, "R2 head held", 64'(q_head), 0);
    chk(q_tail == 3, "R10 tail readback", 64'(q_tail), 3);

    cfg_write(2'd3, 64'h1);
    drain("R6 head after first batch");
    compare_all();
    // R2: enabled but empty
    begin
      bit busy = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); busy |= mem_req | inv_valid; end
      chk(!busy, "R2 idle when empty", 64'(busy), 0);
    end
    chk(q_err == 0, "R7 no error yet", 64'(q_err), 0);

    // R7 unsupported command
    put_cmd(1, 1, 16'h0042);
    put_cmd(0, 0, 16'h0077);
    cfg_write(2'd2, 64'(sw_tail));
    drain("R7 head advances past bad command");
    chk(q_err == 1, "R7 error set", 64'(q_err), 1);
    compare_all();

    // R10 head write ignored while enabled
    cfg_write(2'd1, 64'd77);
    repeat (4) @(negedge clk);
    chk(q_head == 32'(sw_tail), "R10 head write ignored", 64'(q_head), 64'(sw_tail));

    // random batches
    for (int b = 0; b < 8; b++) begin
      int n;
      n = 1 + ($urandom % 8);
      for (int j = 0; j < n; j++)
        put_cmd(($urandom % 8) == 0, $urandom % 2, 16'($urandom));
      cfg_write(2'd2, 64'(sw_tail));
      drain("R6 random batch drain");
    end
    compare_all();
    chk(q_err == 1, "R7 error sticky", 64'(q_err), 1);

    // R9 wrap
    cfg_write(2'd3, 64'h0);
    cfg_write(2'd1, 64'd4093);
    cfg_write(2'd2, 64'd4093);
    chk(q_head == 4093, "R10 head write accepted", 64'(q_head), 4093);
    sw_tail = 4093; exp_slot = 4093;
    for (int j = 0; j < 5; j++) put_cmd(0, j % 2, 16'(16'h0F00 + j));
    cfg_write(2'd2, 64'(sw_tail));
    cfg_write(2'd3, 64'h1);
    drain("R9 head wraps to 2");
    chk(q_head == 2, "R9 wrapped head", 64'(q_head), 2);
    compare_all();

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule